// File: doc/BRIEF.md
# Byte-Repeating Speed Adapter With Frame-Start Repair

This block takes a byte stream arriving at a 10, 100 or 1000 Mb/s byte rate and turns it into a stream on a single 125 MHz clock. The slow byte rate appears as a one-cycle strobe `in_stb` inside the 125 MHz domain. Every byte accepted on a strobe is played out for as many consecutive 125 MHz cycles as the selected speed needs: once at 1000 Mb/s, ten times at 100 Mb/s and a hundred times at 10 Mb/s. Because the repetition happens on plain bytes, before any line coding, the start-of-frame delimiter still marks a frame only once downstream.

The block also repairs the start of each frame. Every frame it emits opens with at least two 0x55 preamble bytes followed by the 0xD5 delimiter. A frame that arrives with too few 0x55 bytes has 0x55 bytes added in front of its delimiter. A frame with no delimiter at all gets the missing 0x55 bytes and a 0xD5 placed in front of its first non-preamble byte. Each accepted byte is stored in a small queue together with a count of the bytes to add in front of it. An output state machine plays the added bytes, then the stored byte. Because of this, a repaired frame leaves the block up to three byte slots later than it arrived.

The input side is a three-state machine. `FX_WAIT` waits between frames. `FX_PRE` counts leading 0x55 bytes and is entered from `FX_WAIT` or kept on a 0x55 strobe. `FX_BODY` passes the payload and is entered on the first byte that is not 0x55. Any state returns to `FX_WAIT` when `in_en` is low.

The output side is a four-state machine. `OS_IDLE` loads the next queued entry when there is one. `OS_PAD` emits added 0x55 bytes. `OS_SFD` emits an added 0xD5. `OS_DATA` emits the stored byte. Each emitting state holds its byte for the repeat count. After the last repeat it moves on as follows:
- `OS_PAD` goes to the next pad byte, or to `OS_SFD` / `OS_DATA`.
- `OS_SFD` goes to `OS_DATA`.
- `OS_DATA` loads the next entry, or falls back to `OS_IDLE`.

Top module: `gmii_rate_repeater`

## Requirements
- R1: After reset `out_valid`, `out_err` and `speed_rsvd` are 0.
- R2: With `speed_sel` = 2'b01 (100 Mb/s), every output byte is held on 10 consecutive cycles with `out_valid` high.
- R3: With `speed_sel` = 2'b00 (10 Mb/s), every output byte is held on 100 consecutive cycles with `out_valid` high.
- R4: With `speed_sel` = 2'b10 (1000 Mb/s), bytes leave one per cycle with no repetition.
- R5: `speed_sel` = 2'b11 is reserved. It is handled as 1000 Mb/s and sets `speed_rsvd`, which then stays 1 until reset whatever `speed_sel` does.
- R6: A frame whose first bytes are two or more 0x55 followed by 0xD5 leaves the block unchanged. Its first output byte appears 2 cycles after the cycle of its first strobe.
- R7: If fewer than two 0x55 bytes precede the first 0xD5 of a frame, 0x55 bytes are inserted in front of the 0xD5 so that exactly two precede it.
- R8: If the first non-0x55 byte of a frame is not 0xD5, the block inserts 0x55 bytes up to two in total, then one 0xD5, in front of that byte.
- R9: `out_err` repeats the `in_er` value of its byte on every repeat of that byte. It is 0 on inserted bytes and whenever `out_valid` is 0.
- R10: Within a frame `out_valid` has no holes, and it falls in the cycle right after the last repeat of the final byte. This holds provided strobes come exactly once per repeat period and frames are separated by at least four idle byte periods.
- R11: Strobes while `in_en` is 0 produce no output. A low `in_en` also ends the current frame, so the next frame's preamble is counted from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_sel | input | 2 | 00 = 10 Mb/s, 01 = 100 Mb/s, 10 = 1000 Mb/s, 11 = reserved |
| in_stb | input | 1 | One-cycle strobe per slow-rate byte slot |
| in_en | input | 1 | Frame enable for the byte in the slot |
| in_er | input | 1 | Error flag for the byte in the slot |
| in_data | input | 8 | Byte in the slot |
| out_valid | output | 1 | Output byte valid |
| out_err | output | 1 | Output byte error flag |
| out_data | output | 8 | Output byte |
| speed_rsvd | output | 1 | Sticky flag: the reserved speed code was seen |

## Verification
A byte strobed in cycle k enters the queue at the next edge, is loaded by the output machine one edge later, and first shows on the outputs in cycle k+2. It then stays for exactly the repeat count (1, 10 or 100 cycles), and added bytes push the rest of the frame later by whole repeat periods. The scoreboard holds one expected entry per output cycle, not per byte. The monitor checks the frame's first entry against the strobe cycle plus two, then compares every later cycle in turn, so a missing or extra repeat shows up as a data mismatch or a hole. A marker after each frame demands that `out_valid` is low in the cycle right after the last repeat. The sticky flag and the reset state are read directly at the ports between frames.

// File: rtl/gmii_rate_pkg.sv
package gmii_rate_pkg;

    localparam int          BYTE_W       = 8;
    localparam logic [7:0]  PRE_BYTE     = 8'h55;
    localparam logic [7:0]  SFD_BYTE     = 8'hD5;
    localparam int          PREAMBLE_MIN = 2;
    localparam int          PAD_W        = $clog2(PREAMBLE_MIN + 1);

    typedef enum logic [1:0] {
        SP_10   = 2'b00,
        SP_100  = 2'b01,
        SP_1000 = 2'b10,
        SP_RSVD = 2'b11
    } speed_e;

    typedef enum logic [1:0] {
        FX_WAIT,
        FX_PRE,
        FX_BODY
    } fix_state_e;

    typedef enum logic [1:0] {
        OS_IDLE,
        OS_PAD,
        OS_SFD,
        OS_DATA
    } out_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              err;
        logic [PAD_W-1:0]  pad;
        logic              sfd;
    } slot_t;

endpackage

// File: rtl/gmii_rate_speed.sv
module gmii_rate_speed
    import gmii_rate_pkg::*;
#(
    parameter int REP_MID  = 10,
    parameter int REP_SLOW = 100,
    localparam int CNT_W   = $clog2(REP_SLOW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       speed_sel,
    output logic [CNT_W-1:0] rep_last,
    output logic             rsvd_seen
);

    always_comb begin
        unique case (speed_e'(speed_sel))
            SP_10:   rep_last = CNT_W'(REP_SLOW - 1);
            SP_100:  rep_last = CNT_W'(REP_MID - 1);
            SP_1000: rep_last = '0;
            SP_RSVD: rep_last = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rsvd_seen <= 1'b0;
        else if (speed_sel == SP_RSVD)
            rsvd_seen <= 1'b1;
    end

endmodule

// File: rtl/gmii_rate_fixer.sv
module gmii_rate_fixer
    import gmii_rate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_stb,
    input  logic              in_en,
    input  logic              in_er,
    input  logic [BYTE_W-1:0] in_data,
    output logic              push,
    output slot_t             push_item
);

    fix_state_e       st, st_n;
    logic [PAD_W-1:0] pre_cnt, pre_cnt_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= FX_WAIT;
            pre_cnt <= '0;
        end else begin
            st      <= st_n;
            pre_cnt <= pre_cnt_n;
        end
    end

    always_comb begin
        st_n           = st;
        pre_cnt_n      = pre_cnt;
        push           = 1'b0;
        push_item.data = in_data;
        push_item.err  = in_er;
        push_item.pad  = '0;
        push_item.sfd  = 1'b0;
        if (!in_en) begin
            st_n      = FX_WAIT;
            pre_cnt_n = '0;
        end else if (in_stb) begin
            push = 1'b1;
            unique case (st)
                FX_WAIT, FX_PRE: begin
                    if (in_data == PRE_BYTE) begin
                        st_n = FX_PRE;
                        if (pre_cnt != PAD_W'(PREAMBLE_MIN))
                            pre_cnt_n = pre_cnt + 1'b1;
                    end else begin
                        st_n           = FX_BODY;
                        push_item.pad  = PAD_W'(PREAMBLE_MIN) - pre_cnt;
                        push_item.sfd  = (in_data != SFD_BYTE);
                    end
                end
                FX_BODY: st_n = FX_BODY;
                default: st_n = FX_WAIT;
            endcase
        end
    end

endmodule

// File: rtl/gmii_rate_fifo.sv
module gmii_rate_fifo #(
    parameter int W     = 12,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wr_ptr, rd_ptr;

    assign empty = (wr_ptr == rd_ptr);
    assign full  = (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]) && (wr_ptr[AW] != rd_ptr[AW]);
    assign rdata = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push && !full)
                wr_ptr <= wr_ptr + 1'b1;
            if (pop && !empty)
                rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full)
            mem[wr_ptr[AW-1:0]] <= wdata;
    end

endmodule

// File: rtl/gmii_rate_sched.sv
module gmii_rate_sched
    import gmii_rate_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  rep_last,
    input  logic              q_empty,
    input  slot_t             q_head,
    output logic              q_pop,
    output logic              out_valid,
    output logic              out_err,
    output logic [BYTE_W-1:0] out_data,
    output logic [CNT_W-1:0]  rep_cnt
);

    out_state_e       st, st_n;
    logic [CNT_W-1:0] rep_cnt_n;
    logic [PAD_W-1:0] pad_left, pad_left_n;
    slot_t            cur, cur_n;
    logic             last_rep;
    logic             load;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= OS_IDLE;
            rep_cnt  <= '0;
            pad_left <= '0;
            cur      <= '0;
        end else begin
            st       <= st_n;
            rep_cnt  <= rep_cnt_n;
            pad_left <= pad_left_n;
            cur      <= cur_n;
        end
    end

    always_comb begin
        st_n       = st;
        rep_cnt_n  = rep_cnt;
        pad_left_n = pad_left;
        cur_n      = cur;
        load       = 1'b0;
        last_rep   = (rep_cnt >= rep_last);
        unique case (st)
            OS_IDLE: load = !q_empty;
            OS_PAD: begin
                if (last_rep) begin
                    rep_cnt_n = '0;
                    if (pad_left > PAD_W'(1))
                        pad_left_n = pad_left - 1'b1;
                    else
                        st_n = cur.sfd ? OS_SFD : OS_DATA;
                end else begin
                    rep_cnt_n = rep_cnt + 1'b1;
                end
            end
            OS_SFD: begin
                if (last_rep) begin
                    rep_cnt_n = '0;
                    st_n      = OS_DATA;
                end else begin
                    rep_cnt_n = rep_cnt + 1'b1;
                end
            end
            OS_DATA: begin
                if (last_rep) begin
                    rep_cnt_n = '0;
                    if (!q_empty)
                        load = 1'b1;
                    else
                        st_n = OS_IDLE;
                end else begin
                    rep_cnt_n = rep_cnt + 1'b1;
                end
            end
        endcase
        if (load) begin
            cur_n      = q_head;
            pad_left_n = q_head.pad;
            rep_cnt_n  = '0;
            if (q_head.pad != '0)
                st_n = OS_PAD;
            else if (q_head.sfd)
                st_n = OS_SFD;
            else
                st_n = OS_DATA;
        end
        q_pop = load;
    end

    always_comb begin
        out_valid = (st != OS_IDLE);
        out_err   = 1'b0;
        unique case (st)
            OS_IDLE: out_data = '0;
            OS_PAD:  out_data = PRE_BYTE;
            OS_SFD:  out_data = SFD_BYTE;
            OS_DATA: begin
                out_data = cur.data;
                out_err  = cur.err;
            end
        endcase
    end

endmodule

// File: rtl/gmii_rate_repeater.sv
module gmii_rate_repeater
    import gmii_rate_pkg::*;
#(
    parameter int REP_MID    = 10,
    parameter int REP_SLOW   = 100,
    parameter int Q_DEPTH    = 8,
    localparam int CNT_W     = $clog2(REP_SLOW),
    localparam int SLOT_W    = $bits(slot_t)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] speed_sel,
    input  logic       in_stb,
    input  logic       in_en,
    input  logic       in_er,
    input  logic [7:0] in_data,
    output logic       out_valid,
    output logic       out_err,
    output logic [7:0] out_data,
    output logic       speed_rsvd
);

    logic [CNT_W-1:0]  rep_last;
    logic [CNT_W-1:0]  rep_cnt_mon;
    logic              fifo_push, fifo_pop, fifo_empty, fifo_full;
    slot_t             push_item, head_item;
    logic [SLOT_W-1:0] head_raw;

    gmii_rate_speed #(
        .REP_MID  (REP_MID),
        .REP_SLOW (REP_SLOW)
    ) u_speed (
        .clk       (clk),
        .rst_n     (rst_n),
        .speed_sel (speed_sel),
        .rep_last  (rep_last),
        .rsvd_seen (speed_rsvd)
    );

    gmii_rate_fixer u_fixer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_stb    (in_stb),
        .in_en     (in_en),
        .in_er     (in_er),
        .in_data   (in_data),
        .push      (fifo_push),
        .push_item (push_item)
    );

    gmii_rate_fifo #(
        .W     (SLOT_W),
        .DEPTH (Q_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .wdata (push_item),
        .pop   (fifo_pop),
        .rdata (head_raw),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    assign head_item = slot_t'(head_raw);

    gmii_rate_sched #(
        .CNT_W (CNT_W)
    ) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .rep_last  (rep_last),
        .q_empty   (fifo_empty),
        .q_head    (head_item),
        .q_pop     (fifo_pop),
        .out_valid (out_valid),
        .out_err   (out_err),
        .out_data  (out_data),
        .rep_cnt   (rep_cnt_mon)
    );

endmodule

// File: rtl/gmii_rate_repeater_chk.sv
module gmii_rate_repeater_chk #(
    parameter int CNT_W    = 7,
    parameter int REP_MID  = 10,
    parameter int REP_SLOW = 100
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       speed_sel,
    input logic             out_valid,
    input logic             out_err,
    input logic [7:0]       out_data,
    input logic             speed_rsvd,
    input logic             push,
    input logic             full,
    input logic [CNT_W-1:0] rep_cnt
);

    // R2: at 100 Mb/s a byte may change only after its tenth cycle
    assert_hold_mid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_sel == 2'b01 && $stable(speed_sel) && out_valid && rep_cnt != CNT_W'(REP_MID - 1))
        |=> (out_valid && $stable(out_data) && $stable(out_err)));

    // R3: at 10 Mb/s a byte may change only after its hundredth cycle
    assert_hold_slow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_sel == 2'b00 && $stable(speed_sel) && out_valid && rep_cnt != CNT_W'(REP_SLOW - 1))
        |=> (out_valid && $stable(out_data) && $stable(out_err)));

    // R5: reserved code raises the flag
    assert_rsvd_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_sel == 2'b11) |=> speed_rsvd);

    // R5: the flag never clears outside reset
    assert_rsvd_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        speed_rsvd |=> speed_rsvd);

    // R9: no error flag without a valid byte
    assert_err_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_err);

    // R10: the queue never receives a byte it cannot hold
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

endmodule

bind gmii_rate_repeater gmii_rate_repeater_chk #(
    .CNT_W    (CNT_W),
    .REP_MID  (REP_MID),
    .REP_SLOW (REP_SLOW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .speed_sel  (speed_sel),
    .out_valid  (out_valid),
    .out_err    (out_err),
    .out_data   (out_data),
    .speed_rsvd (speed_rsvd),
    .push       (fifo_push),
    .full       (fifo_full),
    .rep_cnt    (rep_cnt_mon)
);

// File: tb/gmii_rate_repeater_tb.sv
module gmii_rate_repeater_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] speed_sel = 2'b10;
    logic       in_stb = 1'b0, in_en = 1'b0, in_er = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_valid, out_err, speed_rsvd;
    logic [7:0] out_data;

    always #4 clk = ~clk;

    gmii_rate_repeater u_dut (
        .clk(clk), .rst_n(rst_n), .speed_sel(speed_sel),
        .in_stb(in_stb), .in_en(in_en), .in_er(in_er), .in_data(in_data),
        .out_valid(out_valid), .out_err(out_err), .out_data(out_data),
        .speed_rsvd(speed_rsvd)
    );

    typedef struct {
        bit         vld;
        logic [7:0] d;
        logic       e;
        int         req;
        bit         first;
    } exp_t;

    exp_t       sb[$];
    logic [7:0] fd[$];
    logic       fe[$];
    int n_chk = 0, n_bad = 0, cyc = 0, t_first = 0;
    bit done = 1'b0, prev_v = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic string rq(int r);
        case (r)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10"; default: return "R11";
        endcase
    endfunction

    task automatic check(bit ok, int r, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq(r), what, act, expv);
        end
    endtask

    // driver: builds the expected per-cycle stream and drives one frame
    task automatic run_frame(input logic [1:0] sp, input int r);
        logic [7:0] od[$];
        logic       oe[$];
        int  rep, c;
        bit  body;
        exp_t it;
        rep  = (sp == 2'b01) ? 10 : (sp == 2'b00) ? 100 : 1;
        c    = 0;
        body = 1'b0;
        for (int i = 0; i < fd.size(); i++) begin
            if (!body && fd[i] == 8'h55) begin
                if (c < 2) c++;
                od.push_back(fd[i]); oe.push_back(fe[i]);
            end else if (!body) begin
                for (int k = c; k < 2; k++) begin od.push_back(8'h55); oe.push_back(1'b0); end
                if (fd[i] != 8'hD5) begin od.push_back(8'hD5); oe.push_back(1'b0); end
                od.push_back(fd[i]); oe.push_back(fe[i]);
                body = 1'b1;
            end else begin
                od.push_back(fd[i]); oe.push_back(fe[i]);
            end
        end
        for (int i = 0; i < od.size(); i++)
            for (int k = 0; k < rep; k++) begin
                it.vld = 1'b1; it.d = od[i]; it.e = oe[i]; it.req = r;
                it.first = (i == 0 && k == 0);
                sb.push_back(it);
            end
        it.vld = 1'b0; it.d = 8'h00; it.e = 1'b0; it.req = 10; it.first = 1'b0;
        sb.push_back(it);

        @(negedge clk);
        speed_sel = sp;
        repeat (3) @(negedge clk);
        t_first = cyc;
        for (int i = 0; i < fd.size(); i++) begin
            in_stb = 1'b1; in_en = 1'b1; in_data = fd[i]; in_er = fe[i];
            @(negedge clk);
            in_stb = 1'b0;
            repeat (rep - 1) @(negedge clk);
        end
        in_en = 1'b0; in_er = 1'b0;
        repeat ((fd.size() + 4) * rep + 10) @(negedge clk);
        check(sb.size() == 0, r, "frame not fully drained", sb.size(), 0);
        sb.delete();
        fd.delete();
        fe.delete();
    endtask

    task automatic add(input logic [7:0] d, input logic e);
        fd.push_back(d);
        fe.push_back(e);
    endtask

    // monitor: compares one expected entry per output cycle
    always @(negedge clk) begin
        exp_t it;
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb.size() == 0 || !sb[0].vld) begin
                    check(1'b0, 10, "valid with nothing expected", out_data, 0);
                    prev_v = 1'b0;
                end else begin
                    it = sb.pop_front();
                    check(out_data == it.d, it.req, "data", out_data, it.d);
                    check(out_err == it.e, 9, "error flag", out_err, it.e);
                    if (it.first)
                        check(cyc == t_first + 2, 6, "first byte cycle", cyc, t_first + 2);
                    prev_v = 1'b1;
                end
            end else begin
                if (prev_v && sb.size() > 0) begin
                    if (sb[0].vld)
                        check(1'b0, 10, "hole inside frame", 0, 1);
                    else begin
                        check(1'b1, 10, "valid drop", 0, 0);
                        void'(sb.pop_front());
                    end
                end
                check(out_err == 1'b0, 9, "error while idle", out_err, 0);
                prev_v = 1'b0;
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired: actual running expected done");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0, 1, "valid after reset", out_valid, 0);
        check(out_err == 1'b0, 1, "err after reset", out_err, 0);
        check(speed_rsvd == 1'b0, 1, "rsvd after reset", speed_rsvd, 0);

        // R4 and R6: full preamble at 1000 Mb/s passes unchanged
        add(8'h55,0); add(8'h55,0); add(8'h55,0); add(8'hD5,0);
        add(8'hA1,0); add(8'hB2,1); add(8'hC3,0);
        run_frame(2'b10, 4);

        // R2 with R9: 100 Mb/s, error on one payload byte
        add(8'h55,0); add(8'h55,0); add(8'hD5,0);
        add(8'h11,0); add(8'h22,1); add(8'h33,0);
        run_frame(2'b01, 2);

        // R3 with R7: 10 Mb/s, one preamble byte short
        add(8'h55,0); add(8'hD5,0); add(8'h7E,1); add(8'h3C,0);
        run_frame(2'b00, 3);

        // R7: no preamble at all at 1000 Mb/s
        add(8'hD5,0); add(8'h01,0); add(8'h02,1);
        run_frame(2'b10, 7);

        // R8: missing delimiter at 100 Mb/s
        add(8'h55,0); add(8'h99,1); add(8'h88,0);
        run_frame(2'b01, 8);

        // R8: missing preamble and delimiter at 1000 Mb/s
        add(8'h42,1); add(8'h43,0);
        run_frame(2'b10, 8);

        // R11: strobes without enable give nothing, and count no preamble
        @(negedge clk);
        speed_sel = 2'b10;
        for (int i = 0; i < 20; i++) begin
            in_stb = 1'b1; in_en = 1'b0; in_data = 8'h55;
            @(negedge clk);
            check(out_valid == 1'b0, 11, "output from disabled strobe", out_valid, 0);
        end
        in_stb = 1'b0;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, 11, "output after disabled strobes", out_valid, 0);
        add(8'h55,0); add(8'hD5,0); add(8'h10,0);
        run_frame(2'b10, 11);

        // R5: reserved code acts as 1000 Mb/s and sets a sticky flag
        check(speed_rsvd == 1'b0, 5, "rsvd before reserved code", speed_rsvd, 0);
        add(8'h55,0); add(8'h55,0); add(8'hD5,0); add(8'hE0,0);
        run_frame(2'b11, 5);
        check(speed_rsvd == 1'b1, 5, "rsvd after reserved code", speed_rsvd, 1);
        add(8'h55,0); add(8'h55,0); add(8'hD5,0); add(8'h5A,0);
        run_frame(2'b01, 5);
        check(speed_rsvd == 1'b1, 5, "rsvd sticky", speed_rsvd, 1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(speed_rsvd == 1'b0, 5, "rsvd cleared by reset", speed_rsvd, 0);
        check(out_valid == 1'b0, 1, "valid after second reset", out_valid, 0);

        finish_run();
    end

endmodule